// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the combinational arithmetic and logic stage of a 32-bit load/store processor. It sits between the operand shifter and the register writeback path. Each cycle it receives these inputs:

- a 4-bit operation code;
- the first operand, taken from a register;
- the second operand, as it leaves the shifter, together with the shifter's carry-out;
- the current condition flags;
- a request to update those flags.

In the same cycle it returns the computed word, a writeback enable and the next value of the flags.

There are sixteen operations in four groups. The first group is bitwise logic. The second is addition and subtraction, including reversed-operand forms and forms that chain the carry flag. The third is mov and invert-mov, which forward the second operand. The fourth is four compare/test operations. These compute a value only to set the flags and never write a register.

The flags are carried as a 4-bit word with N at bit 3, Z at bit 2, C at bit 1 and V at bit 0. When the block does not update the flags, it returns the incoming flag word unchanged. The register that holds the flags, and the logic that evaluates conditions on them, are outside this block.

Top module: `dp_alu`

## Requirements
- R1: Logical operation codes give these results: 0000 a&b, 0001 a^b, 1100 a|b, 1101 b, 1110 a&~b, 1111 ~b, 1000 a&b, 1001 a^b (a = `opnd_a`, b = `opnd_b`).
- R2: Arithmetic operation codes give these results modulo 2^32: 0100 a+b, 0010 a-b, 0011 b-a, 1010 a-b, 1011 a+b.
- R3: `wr_en` is 0 for the compare/test codes 1000, 1001, 1010 and 1011, and 1 for every other code; `result` still carries the computed value.
- R4: The compare/test codes update the flags even when `set_flags` is 0.
- R5: For any other code with `set_flags` at 0, `flags_out` equals `flags_in` on all four bits.
- R6: When the flags update, N (bit 3) equals `result[31]`, and Z (bit 2) is 1 exactly when `result` is zero.
- R7: When the flags update on an arithmetic code:
  - for additions, C (bit 1) is the unsigned carry out of bit 31;
  - for subtractions, C is 1 when the unsigned minuend is at least the subtrahend plus any borrow-in, that is, when no borrow occurs.
- R8: When the flags update on a logical, mov or invert-mov code, C takes `shift_carry`.
- R9: When the flags update, V (bit 0) is set on arithmetic codes exactly when the two's-complement result overflows 32 bits. On all other codes V keeps `flags_in[0]`.
- R10: Carry-chained codes use the incoming C (`flags_in[1]`), as follows:
  - 0101 computes a+b+C;
  - 0110 computes a-b-(1-C);
  - 0111 computes b-a-(1-C).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | First operand (register value) |
| opnd_b | input | 32 | Second operand (shifter output) |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| set_flags | input | 1 | Request to update the flags |
| shift_carry | input | 1 | Carry-out of the shifter |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Register writeback enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
Two behaviours meet in a single evaluation: suppressing writeback and forcing a flag update. A compare/test code with `set_flags` low must clear `wr_en` and still produce fresh N, Z, C and V. The bench provokes this by sending each compare/test code with `set_flags` both low and high, under random incoming flags. Its reference model predicts every output bit independently, so an update that was wrongly blocked, or a write that leaked through, shows up as a miscompare on that vector.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
    OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
    OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
    OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  // Compare/test group: no writeback, forced flag update
  function automatic logic op_is_compare(alu_op_e op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic op_is_arith(alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Operands are exchanged for the reversed subtract forms
  function automatic logic op_swaps(alu_op_e op);
    return (op == OP_RSB) || (op == OP_RSC);
  endfunction

  // Second adder input is inverted for every subtraction
  function automatic logic op_inverts(alu_op_e op);
    case (op)
      OP_SUB, OP_RSB, OP_SBC, OP_RSC, OP_CMP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Adder carry-in: constant 0 or 1, or the chained flag
  function automatic logic op_carry_in(alu_op_e op, logic c_flag);
    case (op)
      OP_SUB, OP_RSB, OP_CMP: return 1'b1;
      OP_ADC, OP_SBC, OP_RSC: return c_flag;
      default:                return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           c_flag,
  output logic [W-1:0]   sum,
  output logic           cout,
  output logic           ovf
);

  localparam int MSB = W - 1;

  function automatic logic [W:0] full_add(logic [W-1:0] x, logic [W-1:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic sign_ovf(logic xs, logic ys, logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [W-1:0] x_in, y_raw, y_in;
  logic         ci;
  logic [W:0]   wide;

  always_comb begin
    x_in  = op_swaps(op) ? b : a;
    y_raw = op_swaps(op) ? a : b;
    y_in  = op_inverts(op) ? ~y_raw : y_raw;
    ci    = op_carry_in(op, c_flag);
    wide  = full_add(x_in, y_in, ci);
    sum   = wide[W-1:0];
    cout  = wide[W];
    ovf   = sign_ovf(x_in[MSB], y_in[MSB], wide[MSB]);
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);

  always_comb begin
    case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end

endmodule

// File: rtl/alu_flagunit.sv
module alu_flagunit
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         upd,
  input  logic         arith,
  input  logic [W-1:0] res,
  input  logic         add_cout,
  input  logic         add_ovf,
  input  logic         shift_carry,
  input  alu_flags_t   f_in,
  output alu_flags_t   f_out
);

  always_comb begin
    f_out = f_in;
    if (upd) begin
      f_out.n = res[W-1];
      f_out.z = (res == '0);
      f_out.c = arith ? add_cout : shift_carry;
      f_out.v = arith ? add_ovf : f_in.v;
    end
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   flags_in,
  input  logic         set_flags,
  input  logic         shift_carry,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [3:0]   flags_out
);

  alu_op_e      op;
  alu_flags_t   f_in, f_out;
  logic         cmp_sel;
  logic         arith_sel;
  logic         upd_flags;
  logic [W-1:0] add_sum, logic_res;
  logic         add_cout, add_ovf;

  assign op        = alu_op_e'(op_code);
  assign f_in      = alu_flags_t'(flags_in);
  assign cmp_sel   = op_is_compare(op);
  assign arith_sel = op_is_arith(op);
  assign upd_flags = set_flags | cmp_sel;

  alu_addsub #(.W(W)) u_addsub (
    .op(op), .a(opnd_a), .b(opnd_b), .c_flag(f_in.c),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .op(op), .a(opnd_a), .b(opnd_b), .res(logic_res)
  );

  assign result = arith_sel ? add_sum : logic_res;
  assign wr_en  = ~cmp_sel;

  alu_flagunit #(.W(W)) u_flags (
    .upd(upd_flags), .arith(arith_sel), .res(result),
    .add_cout(add_cout), .add_ovf(add_ovf), .shift_carry(shift_carry),
    .f_in(f_in), .f_out(f_out)
  );

  assign flags_out = f_out;

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int W = 32
) (
  input logic [3:0]   op_code,
  input logic [3:0]   flags_in,
  input logic         set_flags,
  input logic         shift_carry,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic [3:0]   flags_out,
  input logic         upd_flags,
  input logic         arith_sel
);

  always_comb begin
    if (!$isunknown({op_code, flags_in, set_flags, shift_carry, result})) begin
      // R3
      assert_no_write_on_compare_R3: assert (!(op_code[3:2] == 2'b10 && wr_en));
      // R4
      assert_compare_updates_R4: assert (!(op_code[3:2] == 2'b10 && !upd_flags));
      // R5
      assert_flags_held_R5: assert (upd_flags || flags_out == flags_in);
      // R6
      assert_neg_zero_R6: assert (!upd_flags ||
                                  (flags_out[3] == result[W-1] &&
                                   flags_out[2] == (result == '0)));
      // R8
      assert_logic_carry_R8: assert (!upd_flags || arith_sel ||
                                     flags_out[1] == shift_carry);
      // R9
      assert_v_kept_logical_R9: assert (arith_sel || flags_out[0] == flags_in[0]);
    end
  end

endmodule

bind dp_alu dp_alu_chk #(.W(W)) u_dp_alu_chk (
  .op_code(op_code), .flags_in(flags_in), .set_flags(set_flags),
  .shift_carry(shift_carry), .result(result), .wr_en(wr_en),
  .flags_out(flags_out), .upd_flags(upd_flags), .arith_sel(arith_sel)
);

// File: tb/tb_dp_alu.sv
module tb_dp_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_code = 4'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [3:0]  flags_in = 4'd0;
  logic        set_flags = 1'b0, shift_carry = 1'b0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  dp_alu dut (
    .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
    .set_flags(set_flags), .shift_carry(shift_carry),
    .result(result), .wr_en(wr_en), .flags_out(flags_out)
  );

  // Behavioural reference built on wide integers
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] fi, input logic sf, input logic sc,
                       output logic [31:0] r, output logic we, output logic [3:0] fo);
    longint ua, ub, sa, sb, wide, sw, cin;
    logic   arith, c, v, upd;
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    sa = longint'(signed'(a));
    sb = longint'(signed'(b));
    cin = longint'(fi[1]);
    arith = 1'b1; c = 1'b0; v = 1'b0; wide = 0; sw = 0;
    case (op)
      4'b0100, 4'b1011: begin wide = ua + ub;        c = wide >= 64'sh1_0000_0000; sw = sa + sb; end
      4'b0101:          begin wide = ua + ub + cin;  c = wide >= 64'sh1_0000_0000; sw = sa + sb + cin; end
      4'b0010, 4'b1010: begin wide = ua - ub;        c = ua >= ub;              sw = sa - sb; end
      4'b0110:          begin wide = ua - ub - (1 - cin); c = ua >= ub + (1 - cin); sw = sa - sb - (1 - cin); end
      4'b0011:          begin wide = ub - ua;        c = ub >= ua;              sw = sb - sa; end
      4'b0111:          begin wide = ub - ua - (1 - cin); c = ub >= ua + (1 - cin); sw = sb - sa - (1 - cin); end
      default: arith = 1'b0;
    endcase
    if (arith) begin
      r = wide[31:0];
      v = (sw > 64'sd2147483647) || (sw < -64'sd2147483648);
    end else begin
      case (op)
        4'b0000, 4'b1000: r = a & b;
        4'b0001, 4'b1001: r = a ^ b;
        4'b1100:          r = a | b;
        4'b1101:          r = b;
        4'b1110:          r = a & ~b;
        default:          r = ~b;
      endcase
      c = sc;
    end
    we  = !(op >= 4'd8 && op <= 4'd11);
    upd = sf || !we;
    fo  = fi;
    if (upd) fo = {r[31], r == 32'd0, c, arith ? v : fi[0]};
  endtask

  function automatic string res_tag(input logic [3:0] op);
    if (op == 4'b0101 || op == 4'b0110 || op == 4'b0111) return "R10";
    if (op == 4'b0010 || op == 4'b0011 || op == 4'b0100 || op == 4'b1010 || op == 4'b1011) return "R2";
    return "R1";
  endfunction

  // Drive one vector after a rising edge, judge it at the falling edge
  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] fi, input logic sf, input logic sc);
    logic [31:0] er;
    logic        ew;
    logic [3:0]  ef;
    bit          cmp, arith, bad;
    @(posedge clk);
    op_code = op; opnd_a = a; opnd_b = b; flags_in = fi; set_flags = sf; shift_carry = sc;
    @(negedge clk);
    model(op, a, b, fi, sf, sc, er, ew, ef);
    cmp   = (op[3:2] == 2'b10);
    arith = (op[3:2] == 2'b01) || (op == 4'b0010) || (op == 4'b0011) ||
            (op == 4'b1010) || (op == 4'b1011);
    n_checks++;
    bad = 0;
    if (result !== er) begin
      $display("FAIL %s op=%b result act=%h exp=%h", res_tag(op), op, result, er); bad = 1;
    end
    if (wr_en !== ew) begin
      $display("FAIL R3 op=%b wr_en act=%b exp=%b", op, wr_en, ew); bad = 1;
    end
    if (!sf && !cmp && flags_out !== ef) begin
      $display("FAIL R5 op=%b flags act=%b exp=%b", op, flags_out, ef); bad = 1;
    end else if (flags_out[3:2] !== ef[3:2]) begin
      $display("FAIL %s op=%b NZ act=%b exp=%b", (cmp && !sf) ? "R4" : "R6", op,
               flags_out[3:2], ef[3:2]); bad = 1;
    end else if (flags_out[1] !== ef[1]) begin
      $display("FAIL %s op=%b C act=%b exp=%b", arith ? "R7" : "R8", op, flags_out[1], ef[1]); bad = 1;
    end else if (flags_out[0] !== ef[0]) begin
      $display("FAIL R9 op=%b V act=%b exp=%b", op, flags_out[0], ef[0]); bad = 1;
    end
    if (bad) n_fail++;
  endtask

  function automatic logic [31:0] xs32(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] s;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle state: all-zero inputs act as AND with flags held (R1, R5)
    apply(4'b0000, 32'h0, 32'h0, 4'b0000, 1'b0, 1'b0);
    // R1 logical patterns
    apply(4'b1110, 32'hFFFF_00FF, 32'h0F0F_0F0F, 4'b0101, 1'b1, 1'b1);
    apply(4'b1111, 32'h1234_5678, 32'hFFFF_FFFF, 4'b1011, 1'b1, 1'b0);  // Z set, V kept (R9)
    // R2/R7: carry and overflow boundaries
    apply(4'b0100, 32'hFFFF_FFFF, 32'h0000_0001, 4'b0000, 1'b1, 1'b0);
    apply(4'b0100, 32'h7FFF_FFFF, 32'h0000_0001, 4'b0000, 1'b1, 1'b0);
    apply(4'b0010, 32'h0000_0000, 32'h0000_0001, 4'b0010, 1'b1, 1'b0);
    apply(4'b0010, 32'h8000_0000, 32'h0000_0001, 4'b0000, 1'b1, 1'b0);
    apply(4'b0011, 32'h0000_0005, 32'h0000_0003, 4'b0000, 1'b1, 1'b0);
    // R10 chained carry with C clear and set
    apply(4'b0101, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0010, 1'b1, 1'b0);
    apply(4'b0110, 32'h0000_0005, 32'h0000_0005, 4'b0000, 1'b1, 1'b0);
    apply(4'b0110, 32'h0000_0005, 32'h0000_0005, 4'b0010, 1'b1, 1'b0);
    apply(4'b0111, 32'h0000_0003, 32'h0000_0003, 4'b0000, 1'b1, 1'b0);
    // R3/R4: compare/test with set_flags low must still update flags
    for (int k = 8; k < 12; k++) begin
      apply(4'(k), 32'h8000_0000, 32'h8000_0000, 4'b0000, 1'b0, 1'b1);
      apply(4'(k), 32'h0000_0001, 32'h0000_0002, 4'b1111, 1'b0, 1'b0);
    end
    // R5: no update request leaves flags untouched
    apply(4'b0100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0110, 1'b0, 1'b1);
    // Sweep: every opcode under pseudo-random operands and flags
    s = 32'hACE1_2469;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b, m;
      s = xs32(s); a = s;
      s = xs32(s); b = s;
      s = xs32(s); m = s;
      if (m[9:8] == 2'b00) b = a;
      if (m[11:10] == 2'b00) a = {m[12], 31'h7FFF_FFFF};
      apply(4'(i % 16), a, b, m[3:0], m[4], m[5]);
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule